// File: doc/BRIEF.md
# Transmit Packet Gap Buffer

This block sits between a packet source and a 64-bit AXI4-Stream MAC transmit port. Once the source starts a packet it cannot pause, but the MAC may drop its ready at any point inside a packet. The block closes this gap with a small FIFO. Each entry holds 64 data bits, an 8-bit byte-keep and the last flag. The source sees back-pressure only between packets, never inside one.

An admission state machine decides when the source may start a packet. It has three states. `ADM_WAIT` holds ready low until there is room. `ADM_OPEN` holds ready high for the whole packet. `ADM_GAP` forces a fixed idle gap after each last beat. The transitions are:
- `ADM_WAIT -> ADM_OPEN` when the FIFO word count is below the admit limit and the two-cycle-delayed copy of ready is low.
- `ADM_OPEN -> ADM_GAP` on an accepted last beat.
- `ADM_GAP -> ADM_OPEN` or `ADM_GAP -> ADM_WAIT` when the gap count ends, depending on the same room condition.

Accepted beats pass through one register stage into the FIFO. On the read side, an output machine with states `OUT_EMPTY` and `OUT_LOADED` pulls a word whenever the FIFO is non-empty and the MAC is ready. It presents that word one cycle later:
- `OUT_EMPTY -> OUT_LOADED` on a FIFO read.
- `OUT_LOADED -> OUT_EMPTY` when the MAC takes the beat and no new read happens.

Top module: `txgap_buffer`

## Requirements
- R1: While reset is high, `src_ready` and `mac_tvalid` are 0. After reset falls, `src_ready` goes high at the first clock edge.
- R2: `src_ready` rises only when the FIFO word count is below 16. While the count stays at 16 or more, `src_ready` stays low.
- R3: Once `src_ready` is high, it stays high on every beat of a packet until the beat with `src_last` = 1 is accepted.
- R4: After a last beat is accepted, `src_ready` is low for exactly 3 cycles and then rises again, provided the FIFO has room.
- R5: Every accepted beat reaches the MAC once, in order, with `tdata`, `tkeep` and `tlast` unchanged. One 73-bit entry is stored per beat. The buffer never takes a write while its 32 entries are full, as long as downstream stalls stay under 16 cycles per packet.
- R6: While `mac_tvalid` = 1 and `mac_tready` = 0, `mac_tvalid`, `mac_tdata`, `mac_tkeep` and `mac_tlast` hold their values on the next cycle.
- R7: With an empty FIFO and `mac_tready` high, a beat accepted at clock edge n appears on `mac_tvalid` after edge n+2.
- R8: `mac_tvalid` falls in the cycle after the last buffered beat is taken, when no further beat is buffered.
- R9: The FIFO is read only while `mac_tready` is high. With beats buffered, an empty output stage and `mac_tready` held low, `mac_tvalid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 1 | Source beat valid |
| src_ready | output | 1 | Source may send; held through a packet |
| src_data | input | 64 | Source data |
| src_keep | input | 8 | Source byte-keep |
| src_last | input | 1 | Source last beat of packet |
| mac_tvalid | output | 1 | Beat valid toward the MAC |
| mac_tready | input | 1 | MAC ready |
| mac_tdata | output | 64 | Data toward the MAC |
| mac_tkeep | output | 8 | Byte-keep toward the MAC |
| mac_tlast | output | 1 | Last beat toward the MAC |

## Verification
The bench measures the idle gap after a last beat. A machine that opened early or late would show two or four low cycles instead of three. It stalls the MAC for the whole of a 20-beat packet. A design that ignored the fill level would reopen the source with too little room left, and one that read without ready would raise `tvalid`. Random short MAC stalls across packets of 1 to 40 beats show up any lost, repeated or reordered beat. They also expose a held beat that changes while the MAC is not ready. An exact two-edge latency check exposes any extra or missing pipeline register.

// File: rtl/txgap_pkg.sv
package txgap_pkg;
    localparam int TG_DATA_W = 64;
    localparam int TG_KEEP_W = TG_DATA_W / 8;

    typedef struct packed {
        logic                 last;
        logic [TG_KEEP_W-1:0] keep;
        logic [TG_DATA_W-1:0] data;
    } beat_t;

    typedef enum logic [1:0] {
        ADM_WAIT = 2'd0,
        ADM_OPEN = 2'd1,
        ADM_GAP  = 2'd2
    } adm_state_e;

    typedef enum logic {
        OUT_EMPTY  = 1'b0,
        OUT_LOADED = 1'b1
    } out_state_e;
endpackage

// File: rtl/txgap_fifo.sv
module txgap_fifo
    import txgap_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  beat_t            wr_beat,
    input  logic             rd_en,
    output beat_t            rd_beat,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] fill
);
    beat_t             mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_beat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (rd_en) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({wr_en, rd_en})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign rd_beat = mem[rd_ptr];
    assign empty   = (fill == '0);
    assign full    = (fill == CNT_W'(DEPTH));
endmodule

// File: rtl/txgap_admit.sv
module txgap_admit
    import txgap_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LIMIT = 16,
    parameter int GAP   = 3,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int GW    = $clog2(GAP + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] fill,
    input  logic             src_valid,
    input  logic             src_last,
    output logic             src_ready
);
    adm_state_e       st;
    adm_state_e       st_nx;
    logic [1:0]       rdy_dly;
    logic [GW-1:0]    gap_cnt;
    logic             room_ok;

    // Admission needs space and a quiet delayed ready
    assign room_ok = (fill < CNT_W'(LIMIT)) && !rdy_dly[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ADM_WAIT;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ADM_WAIT: begin
                if (room_ok) begin
                    st_nx = ADM_OPEN;
                end
            end
            ADM_OPEN: begin
                if (src_valid && src_last) begin
                    st_nx = ADM_GAP;
                end
            end
            ADM_GAP: begin
                if (gap_cnt == GW'(GAP - 1)) begin
                    st_nx = room_ok ? ADM_OPEN : ADM_WAIT;
                end
            end
            default: st_nx = ADM_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_dly <= '0;
            gap_cnt <= '0;
        end else begin
            rdy_dly <= {rdy_dly[0], src_ready};
            gap_cnt <= (st == ADM_GAP) ? gap_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        src_ready = (st == ADM_OPEN);
    end
endmodule

// File: rtl/txgap_drain.sv
module txgap_drain
    import txgap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fifo_empty,
    input  beat_t                rd_beat,
    output logic                 fifo_rd,
    input  logic                 mac_tready,
    output logic                 mac_tvalid,
    output logic [TG_DATA_W-1:0] mac_tdata,
    output logic [TG_KEEP_W-1:0] mac_tkeep,
    output logic                 mac_tlast
);
    out_state_e st;
    out_state_e st_nx;
    beat_t      hold;

    // Reads only happen while the MAC accepts
    assign fifo_rd = !fifo_empty && mac_tready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= OUT_EMPTY;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            OUT_EMPTY: begin
                if (fifo_rd) begin
                    st_nx = OUT_LOADED;
                end
            end
            OUT_LOADED: begin
                if (mac_tready && !fifo_rd) begin
                    st_nx = OUT_EMPTY;
                end
            end
            default: st_nx = OUT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (fifo_rd) begin
            hold <= rd_beat;
        end
    end

    always_comb begin
        mac_tvalid = (st == OUT_LOADED);
        mac_tdata  = hold.data;
        mac_tkeep  = hold.keep;
        mac_tlast  = hold.last;
    end
endmodule

// File: rtl/txgap_buffer.sv
module txgap_buffer
    import txgap_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LIMIT = 16,
    parameter int GAP   = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 src_valid,
    output logic                 src_ready,
    input  logic [TG_DATA_W-1:0] src_data,
    input  logic [TG_KEEP_W-1:0] src_keep,
    input  logic                 src_last,
    output logic                 mac_tvalid,
    input  logic                 mac_tready,
    output logic [TG_DATA_W-1:0] mac_tdata,
    output logic [TG_KEEP_W-1:0] mac_tkeep,
    output logic                 mac_tlast
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             wr_q;
    beat_t            wr_beat_q;
    beat_t            rd_beat;
    logic             fifo_rd;
    logic             fifo_empty;
    logic             fifo_full;
    logic [CNT_W-1:0] fifo_fill;

    // One register stage between handshake and FIFO write
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q      <= 1'b0;
            wr_beat_q <= '0;
        end else begin
            wr_q      <= src_valid && src_ready;
            wr_beat_q <= '{last: src_last, keep: src_keep, data: src_data};
        end
    end

    txgap_admit #(.DEPTH(DEPTH), .LIMIT(LIMIT), .GAP(GAP)) u_admit (
        .clk       (clk),
        .rst       (rst),
        .fill      (fifo_fill),
        .src_valid (src_valid),
        .src_last  (src_last),
        .src_ready (src_ready)
    );

    txgap_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_q),
        .wr_beat (wr_beat_q),
        .rd_en   (fifo_rd),
        .rd_beat (rd_beat),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .fill    (fifo_fill)
    );

    txgap_drain u_drain (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .rd_beat    (rd_beat),
        .fifo_rd    (fifo_rd),
        .mac_tready (mac_tready),
        .mac_tvalid (mac_tvalid),
        .mac_tdata  (mac_tdata),
        .mac_tkeep  (mac_tkeep),
        .mac_tlast  (mac_tlast)
    );
endmodule

// File: rtl/txgap_checker.sv
module txgap_checker
    import txgap_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LIMIT = 16,
    parameter int GAP   = 3,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int GW    = $clog2(GAP + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 src_valid,
    input logic                 src_ready,
    input logic                 src_last,
    input logic                 mac_tvalid,
    input logic                 mac_tready,
    input logic [TG_DATA_W-1:0] mac_tdata,
    input logic [TG_KEEP_W-1:0] mac_tkeep,
    input logic                 mac_tlast,
    input logic [CNT_W-1:0]     fill,
    input logic                 wr_en,
    input logic                 full
);
    logic [GW-1:0] since_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_last <= GW'(GAP);
        end else if (src_valid && src_ready && src_last) begin
            since_last <= '0;
        end else if (since_last != GW'(GAP)) begin
            since_last <= since_last + 1'b1;
        end
    end

    // R3
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (src_valid && src_ready && !src_last) |=> src_ready);

    // R4
    gap_len_chk: assert property (@(posedge clk) disable iff (rst)
        src_ready |-> (since_last == GW'(GAP)));

    // R2
    room_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(src_ready) |-> ($past(fill) < CNT_W'(LIMIT)));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mac_tvalid && !mac_tready) |=>
            (mac_tvalid && $stable(mac_tdata) && $stable(mac_tkeep) && $stable(mac_tlast)));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);
endmodule

bind txgap_buffer txgap_checker #(.DEPTH(DEPTH), .LIMIT(LIMIT), .GAP(GAP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_valid  (src_valid),
    .src_ready  (src_ready),
    .src_last   (src_last),
    .mac_tvalid (mac_tvalid),
    .mac_tready (mac_tready),
    .mac_tdata  (mac_tdata),
    .mac_tkeep  (mac_tkeep),
    .mac_tlast  (mac_tlast),
    .fill       (fifo_fill),
    .wr_en      (wr_q),
    .full       (fifo_full)
);

// File: tb/txgap_buffer_bench.sv
module txgap_buffer_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        src_valid;
    logic        src_ready;
    logic [63:0] src_data;
    logic [7:0]  src_keep;
    logic        src_last;
    logic        mac_tvalid;
    logic        mac_tready;
    logic [63:0] mac_tdata;
    logic [7:0]  mac_tkeep;
    logic        mac_tlast;

    int checks = 0;
    int errors = 0;
    int popped = 0;
    int sent   = 0;
    int budget = 0;
    logic stall_en  = 1'b0;
    logic force_low = 1'b0;

    logic [72:0] exp_q[$];
    logic [72:0] exp_b;
    logic [72:0] hold_b;
    logic        hold_v = 1'b0;

    always #5 clk = ~clk;

    txgap_buffer u_txgap_buffer (
        .clk(clk), .rst(rst),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .src_keep(src_keep), .src_last(src_last),
        .mac_tvalid(mac_tvalid), .mac_tready(mac_tready), .mac_tdata(mac_tdata),
        .mac_tkeep(mac_tkeep), .mac_tlast(mac_tlast)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [72:0] act, input logic [72:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Scoreboard and hold monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (rst) begin
            hold_v = 1'b0;
        end else begin
            if (src_valid && src_ready) begin
                exp_q.push_back({src_last, src_keep, src_data});
            end
            if (hold_v) begin
                check(mac_tvalid && ({mac_tlast, mac_tkeep, mac_tdata} == hold_b), "R6",
                      "beat changed under stall", {mac_tlast, mac_tkeep, mac_tdata}, hold_b);
            end
            if (mac_tvalid && mac_tready) begin
                popped++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected beat", {mac_tlast, mac_tkeep, mac_tdata}, '0);
                end else begin
                    exp_b = exp_q.pop_front();
                    check({mac_tlast, mac_tkeep, mac_tdata} == exp_b, "R5", "beat content/order",
                          {mac_tlast, mac_tkeep, mac_tdata}, exp_b);
                end
            end
            hold_v = mac_tvalid && !mac_tready;
            hold_b = {mac_tlast, mac_tkeep, mac_tdata};
        end
    end

    // MAC ready driver
    initial begin
        mac_tready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            if (force_low) begin
                mac_tready = 1'b0;
            end else if (stall_en && budget > 0 && ($urandom % 3 == 0)) begin
                mac_tready = 1'b0;
                budget--;
            end else begin
                mac_tready = 1'b1;
            end
        end
    end

    task automatic send_pkt(input int len, input logic [63:0] base);
        while (!src_ready) begin
            @(posedge clk);
            #1;
        end
        if (stall_en) budget = 12;
        for (int i = 0; i < len; i++) begin
            src_valid = 1'b1;
            src_data  = base + 64'(i);
            src_keep  = (i == len - 1) ? (8'hFF >> (len % 8)) : 8'hFF;
            src_last  = (i == len - 1);
            // R3: ready must still be high for every beat of the packet
            check(src_ready, "R3", "ready dropped mid-packet", 73'(src_ready), 73'd1);
            @(posedge clk);
            #1;
            sent++;
        end
        src_valid = 1'b0;
        src_last  = 1'b0;
    endtask

    task automatic drain_all();
        for (int i = 0; i < 400; i++) begin
            if (exp_q.size() == 0 && !mac_tvalid) break;
            @(posedge clk);
            #1;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        src_valid = 1'b0; src_last = 1'b0; src_data = '0; src_keep = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check(!src_ready, "R1", "src_ready in reset", 73'(src_ready), 73'd0);
        check(!mac_tvalid, "R1", "mac_tvalid in reset", 73'(mac_tvalid), 73'd0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(!src_ready, "R1", "src_ready before first edge", 73'(src_ready), 73'd0);
        @(negedge clk);
        check(src_ready, "R1", "src_ready after first edge", 73'(src_ready), 73'd1);
        @(posedge clk);
        #1;
    endtask

    task automatic t_latency();
        send_pkt(1, 64'hA000);
        @(negedge clk);
        check(!mac_tvalid, "R7", "tvalid after edge n", 73'(mac_tvalid), 73'd0);
        @(negedge clk);
        check(!mac_tvalid, "R7", "tvalid after edge n+1", 73'(mac_tvalid), 73'd0);
        @(negedge clk);
        check(mac_tvalid, "R7", "tvalid after edge n+2", 73'(mac_tvalid), 73'd1);
        @(negedge clk);
        check(!mac_tvalid, "R8", "tvalid after final beat taken", 73'(mac_tvalid), 73'd0);
        @(posedge clk);
        #1;
        drain_all();
    endtask

    task automatic t_gap();
        int lows = 0;
        bit seen = 1'b0;
        send_pkt(4, 64'hB000);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!seen) begin
                if (src_ready) seen = 1'b1;
                else lows++;
            end
        end
        // R4
        check(seen && lows == 3, "R4", "ready-low cycles after last", 73'(lows), 73'd3);
        @(posedge clk);
        #1;
        drain_all();
    endtask

    task automatic t_admit();
        bit rose = 1'b0;
        bit stuck_ok = 1'b1;
        bit quiet_ok = 1'b1;
        force_low = 1'b1;
        @(posedge clk);
        #1;
        send_pkt(20, 64'hC000);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (src_ready) stuck_ok = 1'b0;
            if (mac_tvalid) quiet_ok = 1'b0;
        end
        // R2: 20 words buffered, no admission
        check(stuck_ok, "R2", "ready rose with fill >= 16", 73'(!stuck_ok), 73'd0);
        // R9: no read without MAC ready
        check(quiet_ok, "R9", "tvalid while MAC not ready", 73'(!quiet_ok), 73'd0);
        @(posedge clk);
        #1;
        force_low = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (src_ready) rose = 1'b1;
        end
        check(rose, "R2", "ready returns once drained", 73'(rose), 73'd1);
        @(posedge clk);
        #1;
        drain_all();
    endtask

    task automatic t_random();
        int lens[7] = '{1, 3, 8, 17, 33, 40, 2};
        stall_en = 1'b1;
        foreach (lens[k]) begin
            send_pkt(lens[k], 64'h1_0000 * 64'(k + 1));
        end
        stall_en = 1'b0;
        budget = 0;
        drain_all();
        // R5
        check(exp_q.size() == 0, "R5", "beats left undelivered", 73'(exp_q.size()), 73'd0);
        check(popped == sent, "R5", "delivered beat count", 73'(popped), 73'(sent));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_gap();
        t_admit();
        t_random();
        report();
        $finish;
    end
endmodule